// File: doc/BRIEF.md
# Power-On Reset Release Controller with Test Override

This block produces the reset that holds the rest of a small real-time-clock register file while power comes up. After its own power-on input goes high, the block keeps the core in reset until the crystal oscillator reports that it is running. All inputs are sampled by a fast free-running clock, and SDA, SCL and the oscillator flag each pass through a synchronizer first.

For production test, reset can be released early. The tester drives a fixed, slowly timed sequence of level changes on the two-wire bus lines. When the sequence is accepted, the block enters override mode and lets the core out of reset at once. A test-enable bit in the first register ends override mode when software clears it. While that bit is clear, the sequence is ignored, so the bit also decides whether override can be entered again.

While reset is held, the block owns the 16-byte register map and loads the defined values into its reset-controlled bits on every cycle. Every other bit keeps its contents. Once reset is released, the write port updates whole bytes.

Top module: `rtc_por_ctrl`

## Requirements
- R1: While `por_n` is low at a clock edge, `core_rst_n` and `override_active` are 0 after that edge.
- R2: After `por_n` rises, `core_rst_n` stays 0 until `osc_ready` is seen high. It rises at the third clock edge after `osc_ready` is first presented high: two synchronizer stages, then the phase register.
- R3: The override sequence starts from both lines high. Its five steps, with the levels {SDA,SCL} reached after each, are: SDA falls (01), SCL falls (00), SDA rises (10), SDA falls (00), SCL rises (01). Each edge must come at least `CYC_PER_GAP` clocks after the previous edge of either line. When the whole sequence is accepted, `override_active` and `core_rst_n` are 1 at the third edge after the final step, even if the oscillator is not ready.
- R4: An edge that arrives `CYC_PER_GAP-1` clocks after the previous edge resets the detector to step one, whatever step it falls on. No override follows, and a complete well-spaced sequence sent afterwards is accepted.
- R5: An edge that does not match the expected step, including both lines changing in the same clock, also returns the detector to step one.
- R6: While reset is held, the register map is loaded as follows:
  - address 0 becomes 08h and address 1 becomes 00h;
  - bit 7 is set in addresses 2, 9, 10, 11 and 12;
  - address 13 gets bit 7 = 1 and bits 1:0 = 00;
  - address 14 gets bit 7 = 0 and bits 1:0 = 11.
- R7: A write (`wr_en`, `wr_addr`, `wr_data`) replaces the addressed byte only while `core_rst_n` is 1. Writes made while reset is held have no effect. `rd_data` shows the byte at `rd_addr` combinationally.
- R8: The test-enable bit is bit 3 of address 0 and resets to 1. Writing a 0 to it clears `override_active` at that write's edge. `core_rst_n` stays 1 once released until `por_n` goes low.
- R9: While the test-enable bit is 0, a valid sequence does not set `override_active`. After the bit is written back to 1, a valid sequence sets it again.
- R10: Bits outside the reset-controlled set keep their value through a reset hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| por_n | input | 1 | Power-on reset of the controller, active low, synchronous |
| osc_ready | input | 1 | Oscillator running indication, asynchronous |
| sda_in | input | 1 | Sampled data line of the two-wire bus |
| scl_in | input | 1 | Sampled clock line of the two-wire bus |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Byte at `rd_addr` |
| core_rst_n | output | 1 | Reset to the rest of the clock, active low |
| override_active | output | 1 | Test override mode is active |

## Verification
The hardest case to reach is an edge that breaks the spacing rule by exactly one clock at a chosen step. That step can be the first edge, placed right after the edge that restores the lines, or any later step. The bench changes the lines only at falling clock edges and counts rising edges between changes, so the synchronized edges are spaced by exactly the number of cycles chosen. It sends the sequence with the short gap at each of the five positions in turn, then at random positions mixed with well-spaced sequences. It also sends a sequence while the test-enable bit is clear, and another during a second power-on hold in which the oscillator stays off.

// File: rtl/porx_pkg.sv
// Shared constants and helper functions for the reset release controller.
// Assumes a 16-byte register map with 8-bit bytes.
package porx_pkg;

    localparam int AW        = 4;
    localparam int DW        = 8;
    localparam int NREG      = 1 << AW;
    localparam int TESTC_BIT = 3;
    localparam int STEPS     = 5;

    typedef enum logic {ST_HOLD, ST_RUN} ph_t;

    // Bits of each register that take a defined value while reset is held.
    function automatic logic [DW-1:0] rst_mask(input logic [AW-1:0] a);
        case (a)
            4'h0, 4'h1:                      return 8'hFF;
            4'h2, 4'h9, 4'hA, 4'hB, 4'hC:    return 8'h80;
            4'hD, 4'hE:                      return 8'h83;
            default:                         return 8'h00;
        endcase
    endfunction

    // Values loaded into the masked bits.
    function automatic logic [DW-1:0] rst_val(input logic [AW-1:0] a);
        case (a)
            4'h0:                                  return 8'h08;
            4'h2, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD:    return 8'h80;
            4'hE:                                  return 8'h03;
            default:                               return 8'h00;
        endcase
    endfunction

    // Line levels {sda,scl} before step 0 (k=0) and after each step (k=1..5).
    function automatic logic [1:0] seq_lvl(input logic [2:0] k);
        case (k)
            3'd0:    return 2'b11;
            3'd1:    return 2'b01;
            3'd2:    return 2'b00;
            3'd3:    return 2'b10;
            3'd4:    return 2'b00;
            default: return 2'b01;
        endcase
    endfunction

endpackage

// File: rtl/porx_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent; RST_VAL gives the idle level after reset.
module porx_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    // First stage captures the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage copies the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[i] <= RST_VAL;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/porx_seq_det.sv
// Detects the five-step override sequence on synchronized SDA/SCL levels.
// Every level change must come at least GAP clocks after the previous change
// of either line; a change that is too early or does not match the expected
// step sends the detector back to step one. Assumes inputs are synchronized.
module porx_seq_det
    import porx_pkg::*;
#(
    parameter int GAP = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sda,
    input  logic scl,
    output logic hit
);

    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] GAP_C = CW'(GAP);

    logic [1:0]    prev_q;
    logic [1:0]    now_lv;
    logic [CW-1:0] cnt_q;
    logic [2:0]    step_q;
    logic          edge_seen, spaced, good;

    assign now_lv    = {sda, scl};
    assign edge_seen = (now_lv != prev_q);
    assign spaced    = (cnt_q == GAP_C);
    assign good      = edge_seen && spaced &&
                       (prev_q == seq_lvl(step_q)) &&
                       (now_lv == seq_lvl(step_q + 3'd1));
    assign hit       = en && good && (step_q == 3'(STEPS - 1));

    // Remember the last seen line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 2'b11;
        else        prev_q <= now_lv;
    end

    // Clocks since the last change, saturating at GAP.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (edge_seen) cnt_q <= CW'(1);
        else if (!spaced)   cnt_q <= cnt_q + CW'(1);
    end

    // Step tracker: advance on a good change, otherwise restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  step_q <= '0;
        else if (edge_seen) step_q <= (good && step_q != 3'(STEPS - 1)) ? step_q + 3'd1 : 3'd0;
    end

    a_r4_early_edge_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !spaced) |=> (step_q == 3'd0));

    a_r5_wrong_edge_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && (now_lv != seq_lvl(step_q + 3'd1))) |=> (step_q == 3'd0));

    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (step_q == 3'd0));

    a_r3_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        step_q < 3'(STEPS));

endmodule

// File: rtl/porx_regmap.sv
// 16-byte register map. While hold (or rst_n low) is active, the
// reset-controlled bits are loaded every clock and all other bits keep their
// value; otherwise whole-byte writes apply. Reads are combinational.
module porx_regmap
    import porx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          testc
);

    logic [DW-1:0] mem_q [NREG];

    // Reset load of masked bits during hold, byte writes otherwise.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n || hold)
                mem_q[i] <= (mem_q[i] & ~rst_mask(AW'(i))) | (rst_val(AW'(i)) & rst_mask(AW'(i)));
            else if (wr_en && wr_addr == AW'(i))
                mem_q[i] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign testc   = mem_q[0][TESTC_BIT];

    a_r6_reset_load: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (mem_q[0] == 8'h08 && mem_q[1] == 8'h00 && mem_q[2][7] &&
                  mem_q[13][7] && mem_q[13][1:0] == 2'b00 &&
                  !mem_q[14][7] && mem_q[14][1:0] == 2'b11));

    a_r7_hold_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && wr_en && wr_addr == AW'(3)) |=> $stable(mem_q[3]));

endmodule

// File: rtl/rtc_por_ctrl.sv
// Reset release controller for the clock register file. Holds core reset
// after power-on until the oscillator is ready or the override sequence is
// accepted on the bus lines. Owns the test-enable bit (address 0, bit 3),
// which clears override mode and gates re-entry. Assumes clk is free-running.
module rtc_por_ctrl
    import porx_pkg::*;
#(
    parameter int CYC_PER_GAP = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          osc_ready,
    input  logic          sda_in,
    input  logic          scl_in,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          core_rst_n,
    output logic          override_active
);

    logic [2:0] raw_in, syn_in;
    logic       osc_s, scl_s, sda_s;
    ph_t        ph_q;
    logic       ovr_q, hit, testc, det_en, tc_clear, hold;

    assign raw_in = {osc_ready, scl_in, sda_in};

    porx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign {osc_s, scl_s, sda_s} = syn_in;
    assign det_en = testc & ~ovr_q;
    assign hold   = (ph_q == ST_HOLD);

    porx_seq_det #(.GAP(CYC_PER_GAP)) u_det (
        .clk   (clk),
        .rst_n (por_n),
        .en    (det_en),
        .sda   (sda_s),
        .scl   (scl_s),
        .hit   (hit)
    );

    porx_regmap u_map (
        .clk     (clk),
        .rst_n   (por_n),
        .hold    (hold),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .testc   (testc)
    );

    assign tc_clear = !hold && wr_en && (wr_addr == AW'(0)) && !wr_data[TESTC_BIT];

    // Reset phase: hold until oscillator ready or override accepted.
    always_ff @(posedge clk) begin
        if (!por_n)                      ph_q <= ST_HOLD;
        else if (hold && (osc_s || hit)) ph_q <= ST_RUN;
    end

    // Override flag: set by an accepted sequence, cleared by test-enable write.
    always_ff @(posedge clk) begin
        if (!por_n)        ovr_q <= 1'b0;
        else if (tc_clear) ovr_q <= 1'b0;
        else if (hit)      ovr_q <= 1'b1;
    end

    assign core_rst_n      = (ph_q == ST_RUN);
    assign override_active = ovr_q;

    a_r1_por_holds: assert property (@(posedge clk)
        !por_n |=> (!core_rst_n && !override_active));

    a_r2_release_cause: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst_n) |-> ($past(osc_s) || $past(hit)));

    a_r8_clear_ends_override: assert property (@(posedge clk) disable iff (!por_n)
        tc_clear |=> !override_active);

    a_r8_release_sticky: assert property (@(posedge clk) disable iff (!por_n)
        core_rst_n |=> core_rst_n);

endmodule

// File: tb/rtc_por_ctrl_bench.sv
module rtc_por_ctrl_bench;

    localparam int CLK_PERIOD = 20;
    localparam int GAP        = 25;

    logic       clk = 1'b0;
    logic       por_n, osc_ready, sda_in, scl_in, wr_en;
    logic [3:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic       core_rst_n, override_active;

    rtc_por_ctrl #(.CYC_PER_GAP(GAP), .SYNC_STAGES(2)) u_rtc_por_ctrl (
        .clk(clk), .por_n(por_n), .osc_ready(osc_ready), .sda_in(sda_in),
        .scl_in(scl_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .core_rst_n(core_rst_n),
        .override_active(override_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    logic pre_rst;
    logic [7:0] m_val   [16];
    logic [7:0] m_known [16];

    // Expected reset-controlled bits, from R6.
    function automatic logic [7:0] exp_mask(input int a);
        if (a == 0 || a == 1) return 8'hFF;
        if (a == 2 || (a >= 9 && a <= 12)) return 8'h80;
        if (a == 13 || a == 14) return 8'h83;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_val(input int a);
        if (a == 0) return 8'h08;
        if (a == 2 || (a >= 9 && a <= 13)) return 8'h80;
        if (a == 14) return 8'h03;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_reset();
        for (int a = 0; a < 16; a++) begin
            m_val[a]   = (m_val[a] & ~exp_mask(a)) | (exp_val(a) & exp_mask(a));
            m_known[a] = m_known[a] | exp_mask(a);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        bit running;
        running = core_rst_n;
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        tick(1);
        wr_en = 1'b0;
        if (running) begin
            m_val[a]   = d;
            m_known[a] = 8'hFF;
        end
    endtask

    task automatic rd_chk(input int a, input string req);
        rd_addr = 4'(a);
        #1;
        chk(req, $sformatf("reg %0d", a), rd_data & m_known[a], m_val[a] & m_known[a]);
    endtask

    // Sends the sequence; short_at picks the step whose gap is one clock short (-1: none).
    task automatic send_pat(input int short_at);
        logic [1:0] lv [5];
        lv[0] = 2'b01; lv[1] = 2'b00; lv[2] = 2'b10; lv[3] = 2'b00; lv[4] = 2'b01;
        if (!(sda_in && scl_in)) sda_in = 1'b1;
        for (int k = 0; k < 5; k++) begin
            int sp;
            sp = (k == short_at) ? GAP - 1 : GAP + int'($urandom_range(0, 6));
            tick(sp);
            if (k == 4) pre_rst = core_rst_n;
            {sda_in, scl_in} = lv[k];
        end
        tick(3);
    endtask

    task automatic clear_ovr();
        wr(0, 8'h00);
        wr(0, 8'h08);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        por_n = 1'b0; osc_ready = 1'b0; sda_in = 1'b1; scl_in = 1'b1;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        for (int a = 0; a < 16; a++) begin m_val[a] = '0; m_known[a] = '0; end

        tick(4);
        chk("R1", "core_rst_n in por", core_rst_n, 0);
        chk("R1", "override in por", override_active, 0);
        model_reset();
        por_n = 1'b1;
        tick(1);
        for (int a = 0; a < 16; a++) rd_chk(a, "R6");
        tick(40);
        chk("R2", "held without osc", core_rst_n, 0);

        osc_ready = 1'b1;
        tick(2);
        chk("R2", "two edges after osc", core_rst_n, 0);
        tick(1);
        chk("R2", "third edge after osc", core_rst_n, 1);

        // R7: random byte writes while running
        for (int i = 0; i < 40; i++) begin
            int a;
            logic [7:0] d;
            a = int'($urandom_range(0, 15));
            d = 8'($urandom());
            if (a == 0) d[3] = 1'b1;
            wr(a, d);
        end
        for (int a = 0; a < 16; a++) rd_chk(a, "R7");

        // Second power-on with the oscillator off: R10 retention, R7 writes ignored
        wr(3, 8'hA5);
        osc_ready = 1'b0;
        por_n = 1'b0;
        tick(2);
        chk("R1", "core_rst_n in second por", core_rst_n, 0);
        model_reset();
        por_n = 1'b1;
        tick(1);
        wr(3, 8'h00);
        wr(0, 8'h00);
        rd_chk(3, "R10");
        rd_chk(0, "R7");
        for (int a = 0; a < 16; a++) rd_chk(a, "R6");
        chk("R2", "held with osc off", core_rst_n, 0);

        // R3: valid sequence during hold releases reset
        send_pat(-1);
        chk("R2", "held before final step", pre_rst, 0);
        chk("R3", "override set", override_active, 1);
        chk("R3", "reset released by override", core_rst_n, 1);

        // R8: clearing the test-enable bit
        wr(0, 8'h00);
        chk("R8", "override cleared", override_active, 0);
        tick(5);
        chk("R8", "reset stays released", core_rst_n, 1);

        // R9: sequence ignored while test-enable is 0, accepted after rewrite
        send_pat(-1);
        chk("R9", "ignored with bit clear", override_active, 0);
        wr(0, 8'h08);
        send_pat(-1);
        chk("R9", "re-entry after bit set", override_active, 1);
        clear_ovr();

        // R4: one clock short at each step
        for (int p = 0; p < 5; p++) begin
            send_pat(p);
            chk("R4", $sformatf("short gap at step %0d", p), override_active, 0);
        end
        send_pat(-1);
        chk("R4", "restart after abort", override_active, 1);
        clear_ovr();

        // R5: out-of-order edge
        sda_in = 1'b1;
        tick(GAP + 2);
        {sda_in, scl_in} = 2'b01; tick(GAP + 1);
        {sda_in, scl_in} = 2'b00; tick(GAP + 1);
        {sda_in, scl_in} = 2'b01; tick(GAP + 1);
        {sda_in, scl_in} = 2'b00; tick(GAP + 1);
        {sda_in, scl_in} = 2'b01; tick(3);
        chk("R5", "wrong step rejected", override_active, 0);
        sda_in = 1'b1; tick(GAP + 1);
        {sda_in, scl_in} = 2'b00; tick(GAP + 1);
        chk("R5", "both lines at once rejected", override_active, 0);
        {sda_in, scl_in} = 2'b01;
        send_pat(-1);
        chk("R5", "accepted after restart", override_active, 1);
        clear_ovr();

        // Random mix of short and valid sequences
        for (int i = 0; i < 10; i++) begin
            int r;
            int sa;
            r  = int'($urandom_range(0, 5));
            sa = (r == 5) ? -1 : r;
            send_pat(sa);
            chk(sa < 0 ? "R3" : "R4", $sformatf("random short_at %0d", sa),
                override_active, (sa < 0) ? 1 : 0);
            if (override_active) clear_ovr();
        end
        chk("R8", "still released at end", core_rst_n, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule